// File: doc/BRIEF.md
# Dual-Clock Mixed-Width FIFO

This block is a first-in first-out buffer between two unrelated clock domains. The producer writes words of one width on its own clock, and the consumer reads words of another width on a second clock. The two widths may be equal, or one may be a power-of-two multiple of the other, in either direction. Storage is kept in units of the narrower width. A wide access moves several consecutive narrow words, with the earliest narrow word in the least significant slice.

Each side sees its own view of the buffer. It has a fill count in its own word size, a full flag, an empty flag, and almost-full and almost-empty flags built from that count. The full flag on the write side and the empty flag on the read side decide whether a request is taken. The other side's copy of each flag is that flag passed through a two-stage synchroniser, so it lags by a few cycles. Pointers cross between the domains in Gray code. Each domain has its own active-low asynchronous reset.

Top module: `xclk_mixw_fifo`

## Requirements
- R1: Data leaves in write order. When the read side is wider, a read word holds consecutive write words, with the earliest one in the least significant slice. When the write side is wider, its least significant slice is read first. When the widths are equal, q equals the written data.
- R2: A write request made while wr_full_o is high is ignored. The stored data and both counts are unchanged.
- R3: A read request made while rd_empty_o is high is ignored. rd_data_o and both counts are unchanged.
- R4: rd_full_o is the write-side full condition, synchronised into the read clock. With no further activity it settles to the value of wr_full_o within a few read clocks.
- R5: wr_empty_o is the read-side empty condition, synchronised into the write clock. With no further activity it settles to the value of rd_empty_o.
- R6: On each side, the almost-full flag is high exactly when that side's count is greater than or equal to its almost-full threshold.
- R7: On each side, the almost-empty flag is high exactly when that side's count is strictly below its almost-empty threshold.
- R8: wr_usedw_o counts stored data in write words, rounded up. rd_usedw_o counts complete read words, rounded down. With no activity in flight, both reflect the same stored narrow words.
- R9: wr_full_o is high exactly when wr_usedw_o equals the write-side depth. rd_empty_o is high exactly when rd_usedw_o is zero.
- R10: After reset, both empty flags are high, both full flags are low, both counts are zero and rd_data_o is zero.
- R11: rd_data_o is registered. The data of an accepted read appears after the read clock edge that accepts it, and it holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock |
| wr_rst_ni | input | 1 | Write-domain reset, active low, asynchronous |
| wr_req_i | input | 1 | Write request |
| wr_data_i | input | WR_W | Write data |
| wr_full_o | output | 1 | Full, write domain (authoritative) |
| wr_empty_o | output | 1 | Empty, synchronised copy in the write domain |
| wr_usedw_o | output | AW-log2(WR ratio)+1 | Fill level in write words |
| wr_afull_o | output | 1 | Write-side almost full |
| wr_aempty_o | output | 1 | Write-side almost empty |
| rd_clk_i | input | 1 | Read clock |
| rd_rst_ni | input | 1 | Read-domain reset, active low, asynchronous |
| rd_req_i | input | 1 | Read request |
| rd_data_o | output | RD_W | Read data, registered |
| rd_empty_o | output | 1 | Empty, read domain (authoritative) |
| rd_full_o | output | 1 | Full, synchronised copy in the read domain |
| rd_usedw_o | output | AW-log2(RD ratio)+1 | Fill level in read words |
| rd_afull_o | output | 1 | Read-side almost full |
| rd_aempty_o | output | 1 | Read-side almost empty |

## Verification
The assertions take the following for granted:
- Each request and its data are synchronous to that side's clock.
- Both resets are applied together, so the two pointer sets start from the same origin.
- A domain's count moves against its own traffic by at most one word per cycle.

The bench keeps within these assumptions. It releases both resets at once and drives every input on falling edges. It also uses the ports' own full and empty flags to decide whether each request was taken, so the reference queue stays aligned with what the block accepted. The full and empty boundaries are reached on purpose, and requests are issued there to confirm that they are dropped.

// File: rtl/xwf_pkg.sv
package xwf_pkg;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xwf_sync.sv
module xwf_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= INIT;
      s2_q <= INIT;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xwf_store.sv
module xwf_store #(
  parameter int unsigned NW   = 8,
  parameter int unsigned AW_N = 4,
  parameter int unsigned WR_R = 1,
  parameter int unsigned RD_R = 2,
  localparam int unsigned DEPTH_N = 1 << AW_N
) (
  input  logic               wclk_i,
  input  logic               wen_i,
  input  logic [AW_N-1:0]    waddr_i,
  input  logic [NW*WR_R-1:0] wdata_i,
  input  logic               rclk_i,
  input  logic               rrst_ni,
  input  logic               ren_i,
  input  logic [AW_N-1:0]    raddr_i,
  output logic [NW*RD_R-1:0] rdata_o
);
  logic [NW-1:0] mem [DEPTH_N];

  // base addresses are ratio-aligned, so base+i never wraps
  always_ff @(posedge wclk_i) begin
    if (wen_i)
      for (int i = 0; i < int'(WR_R); i++)
        mem[waddr_i + AW_N'(i)] <= wdata_i[i*NW +: NW];
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) rdata_o <= '0;
    else if (ren_i)
      for (int i = 0; i < int'(RD_R); i++)
        rdata_o[i*NW +: NW] <= mem[raddr_i + AW_N'(i)];
  end
endmodule

// File: rtl/xwf_wr_ctrl.sv
module xwf_wr_ctrl #(
  parameter int unsigned AW_N   = 4,
  parameter int unsigned OWN_K  = 0,
  parameter int unsigned PEER_K = 1,
  parameter int unsigned AF_TH  = 12,
  parameter int unsigned AE_TH  = 3,
  localparam int unsigned PW    = AW_N - OWN_K + 1,
  localparam int unsigned QW    = AW_N - PEER_K + 1,
  localparam int unsigned NPW   = AW_N + 1,
  localparam int unsigned PW1   = PW + 1,
  localparam int unsigned DEPTH = 1 << (AW_N - OWN_K)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [QW-1:0]   peer_gray_i,
  output logic            en_o,
  output logic [AW_N-1:0] addr_o,
  output logic [PW-1:0]   gray_o,
  output logic [PW-1:0]   usedw_o,
  output logic            full_o,
  output logic            afull_o,
  output logic            aempty_o
);
  logic [PW-1:0]  ptr_q, ptr_d, gray_q, usedw;
  logic [NPW-1:0] own_n, peer_n, used_n;
  logic           full, en;

  always_comb begin
    peer_n = NPW'(QW'(xwf_pkg::gray2bin(32'(peer_gray_i)))) << PEER_K;
    own_n  = NPW'(ptr_q) << OWN_K;
    used_n = own_n - peer_n;
    // round up: a partly drained write word still occupies its slot
    usedw  = PW'((used_n + NPW'((1 << OWN_K) - 1)) >> OWN_K);
    full   = (usedw == PW'(DEPTH));
    en     = req_i & ~full;
    ptr_d  = ptr_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else if (en) begin
      ptr_q  <= ptr_d;
      gray_q <= PW'(xwf_pkg::bin2gray(32'(ptr_d)));
    end
  end

  assign en_o     = en;
  assign addr_o   = AW_N'(own_n);
  assign gray_o   = gray_q;
  assign usedw_o  = usedw;
  assign full_o   = full;
  assign afull_o  = (usedw >= PW'(AF_TH));
  assign aempty_o = (usedw < PW'(AE_TH));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && full_o) |=> $stable(ptr_q));
  p_wr_gray_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  p_wr_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usedw_o <= PW'(DEPTH));
  p_wr_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW1'(usedw_o) <= PW1'($past(usedw_o)) + PW1'(1));

  if (AF_TH <= DEPTH) begin : g_af
    p_full_afull_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o |-> afull_o);
  end
endmodule

// File: rtl/xwf_rd_ctrl.sv
module xwf_rd_ctrl #(
  parameter int unsigned AW_N   = 4,
  parameter int unsigned OWN_K  = 1,
  parameter int unsigned PEER_K = 0,
  parameter int unsigned AF_TH  = 6,
  parameter int unsigned AE_TH  = 2,
  localparam int unsigned PW    = AW_N - OWN_K + 1,
  localparam int unsigned QW    = AW_N - PEER_K + 1,
  localparam int unsigned NPW   = AW_N + 1,
  localparam int unsigned PW1   = PW + 1,
  localparam int unsigned DEPTH = 1 << (AW_N - OWN_K)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [QW-1:0]   peer_gray_i,
  output logic            en_o,
  output logic [AW_N-1:0] addr_o,
  output logic [PW-1:0]   gray_o,
  output logic [PW-1:0]   usedw_o,
  output logic            empty_o,
  output logic            afull_o,
  output logic            aempty_o
);
  logic [PW-1:0]  ptr_q, ptr_d, gray_q, usedw;
  logic [NPW-1:0] own_n, peer_n, used_n;
  logic           empty, en;

  always_comb begin
    peer_n = NPW'(QW'(xwf_pkg::gray2bin(32'(peer_gray_i)))) << PEER_K;
    own_n  = NPW'(ptr_q) << OWN_K;
    used_n = peer_n - own_n;
    // round down: only complete read words are readable
    usedw  = PW'(used_n >> OWN_K);
    empty  = (usedw == '0);
    en     = req_i & ~empty;
    ptr_d  = ptr_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else if (en) begin
      ptr_q  <= ptr_d;
      gray_q <= PW'(xwf_pkg::bin2gray(32'(ptr_d)));
    end
  end

  assign en_o     = en;
  assign addr_o   = AW_N'(own_n);
  assign gray_o   = gray_q;
  assign usedw_o  = usedw;
  assign empty_o  = empty;
  assign afull_o  = (usedw >= PW'(AF_TH));
  assign aempty_o = (usedw < PW'(AE_TH));

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && empty_o) |=> $stable(ptr_q));
  p_rd_gray_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  p_rd_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usedw_o <= PW'(DEPTH));
  p_rd_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW1'(usedw_o) + PW1'(1) >= PW1'($past(usedw_o)));

  if (AE_TH > 0) begin : g_ae
    p_empty_aempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o |-> aempty_o);
  end
endmodule

// File: rtl/xclk_mixw_fifo.sv
module xclk_mixw_fifo #(
  parameter int unsigned WR_W       = 8,
  parameter int unsigned RD_W       = 16,
  parameter int unsigned DEPTH_LOG2 = 4,   // storage depth in narrow words
  parameter int unsigned WR_AF_TH   = 12,
  parameter int unsigned WR_AE_TH   = 3,
  parameter int unsigned RD_AF_TH   = 6,
  parameter int unsigned RD_AE_TH   = 2,
  localparam int unsigned NW    = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int unsigned WR_R  = WR_W / NW,
  localparam int unsigned RD_R  = RD_W / NW,
  localparam int unsigned WR_K  = $clog2(WR_R),
  localparam int unsigned RD_K  = $clog2(RD_R),
  localparam int unsigned WR_CW = DEPTH_LOG2 - WR_K + 1,
  localparam int unsigned RD_CW = DEPTH_LOG2 - RD_K + 1
) (
  input  logic             wr_clk_i,
  input  logic             wr_rst_ni,
  input  logic             wr_req_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic             wr_full_o,
  output logic             wr_empty_o,
  output logic [WR_CW-1:0] wr_usedw_o,
  output logic             wr_afull_o,
  output logic             wr_aempty_o,
  input  logic             rd_clk_i,
  input  logic             rd_rst_ni,
  input  logic             rd_req_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             rd_empty_o,
  output logic             rd_full_o,
  output logic [RD_CW-1:0] rd_usedw_o,
  output logic             rd_afull_o,
  output logic             rd_aempty_o
);
  logic                  wr_en, rd_en;
  logic [DEPTH_LOG2-1:0] wr_addr, rd_addr;
  logic [WR_CW-1:0]      wr_gray, wr_gray_rs;
  logic [RD_CW-1:0]      rd_gray, rd_gray_ws;

  xwf_sync #(.W(RD_CW), .INIT('0)) i_sync_rptr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rd_gray), .q_o(rd_gray_ws));

  xwf_sync #(.W(WR_CW), .INIT('0)) i_sync_wptr (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wr_gray), .q_o(wr_gray_rs));

  // status copies for the far side
  xwf_sync #(.W(1), .INIT(1'b0)) i_sync_full (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .d_i(wr_full_o), .q_o(rd_full_o));

  xwf_sync #(.W(1), .INIT(1'b1)) i_sync_empty (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .d_i(rd_empty_o), .q_o(wr_empty_o));

  xwf_wr_ctrl #(
    .AW_N(DEPTH_LOG2), .OWN_K(WR_K), .PEER_K(RD_K), .AF_TH(WR_AF_TH), .AE_TH(WR_AE_TH)
  ) i_wr_ctrl (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .req_i(wr_req_i), .peer_gray_i(rd_gray_ws),
    .en_o(wr_en), .addr_o(wr_addr), .gray_o(wr_gray), .usedw_o(wr_usedw_o),
    .full_o(wr_full_o), .afull_o(wr_afull_o), .aempty_o(wr_aempty_o));

  xwf_rd_ctrl #(
    .AW_N(DEPTH_LOG2), .OWN_K(RD_K), .PEER_K(WR_K), .AF_TH(RD_AF_TH), .AE_TH(RD_AE_TH)
  ) i_rd_ctrl (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .req_i(rd_req_i), .peer_gray_i(wr_gray_rs),
    .en_o(rd_en), .addr_o(rd_addr), .gray_o(rd_gray), .usedw_o(rd_usedw_o),
    .empty_o(rd_empty_o), .afull_o(rd_afull_o), .aempty_o(rd_aempty_o));

  xwf_store #(.NW(NW), .AW_N(DEPTH_LOG2), .WR_R(WR_R), .RD_R(RD_R)) i_store (
    .wclk_i(wr_clk_i), .wen_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data_i),
    .rclk_i(rd_clk_i), .rrst_ni(rd_rst_ni), .ren_i(rd_en), .raddr_i(rd_addr),
    .rdata_o(rd_data_o));

  p_rd_hold_r11: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    !(rd_req_i && !rd_empty_o) |=> $stable(rd_data_o));
endmodule

// File: tb/test_xclk_mixw_fifo.sv
module test_xclk_mixw_fifo;
  // write clock period 8 units (125 MHz at 1 ns), read clock 12 units
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic       wr_req = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] rd_data;
  logic       wr_full, wr_empty, wr_afull, wr_aempty;
  logic       rd_full, rd_empty, rd_afull, rd_aempty;
  logic [4:0] wr_usedw;
  logic [3:0] rd_usedw;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model[$];

  always #4 wr_clk = ~wr_clk;
  always #6 rd_clk = ~rd_clk;

  xclk_mixw_fifo #(
    .WR_W(8), .RD_W(16), .DEPTH_LOG2(4),
    .WR_AF_TH(12), .WR_AE_TH(3), .RD_AF_TH(6), .RD_AE_TH(2)
  ) i_xclk_mixw_fifo (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .wr_empty_o(wr_empty), .wr_usedw_o(wr_usedw),
    .wr_afull_o(wr_afull), .wr_aempty_o(wr_aempty),
    .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_req_i(rd_req), .rd_data_o(rd_data),
    .rd_empty_o(rd_empty), .rd_full_o(rd_full), .rd_usedw_o(rd_usedw),
    .rd_afull_o(rd_afull), .rd_aempty_o(rd_aempty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, output logic acc);
    @(negedge wr_clk);
    wr_data = b;
    wr_req  = 1'b1;
    acc     = !wr_full;
    @(posedge wr_clk);
    if (acc) model.push_back(b);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_req = 1'b0;
  endtask

  task automatic pop(output logic acc, output logic [15:0] got);
    @(negedge rd_clk);
    rd_req = 1'b1;
    acc    = !rd_empty;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_req = 1'b0;
    got    = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic check_levels(input int n);
    int w = n;
    int r = n / 2;
    chk("R8 wr_usedw", 32'(wr_usedw), 32'(w));
    chk("R8 rd_usedw", 32'(rd_usedw), 32'(r));
    chk("R9 wr_full", 32'(wr_full), 32'(w == 16));
    chk("R9 rd_empty", 32'(rd_empty), 32'(r == 0));
    chk("R4 rd_full", 32'(rd_full), 32'(w == 16));
    chk("R5 wr_empty", 32'(wr_empty), 32'(r == 0));
    chk("R6 wr_afull", 32'(wr_afull), 32'(w >= 12));
    chk("R6 rd_afull", 32'(rd_afull), 32'(r >= 6));
    chk("R7 wr_aempty", 32'(wr_aempty), 32'(w < 3));
    chk("R7 rd_aempty", 32'(rd_aempty), 32'(r < 2));
  endtask

  // pops one read word and checks it against the two oldest bytes
  task automatic pop_check(input string tag);
    logic        acc;
    logic [15:0] got, exp;
    pop(acc, got);
    chk({tag, " R9 read taken"}, 32'(acc), 32'(model.size() >= 2));
    if (acc && model.size() >= 2) begin
      exp = {model[1], model[0]};
      chk({tag, " R1 R11 read data"}, 32'(got), 32'(exp));
      void'(model.pop_front());
      void'(model.pop_front());
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic        acc;
    logic [15:0] got, q0;

    repeat (3) @(posedge rd_clk);
    @(negedge wr_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    @(negedge rd_clk);
    // R10 reset state
    chk("R10 wr_empty", 32'(wr_empty), 1);
    chk("R10 rd_empty", 32'(rd_empty), 1);
    chk("R10 wr_full", 32'(wr_full), 0);
    chk("R10 rd_full", 32'(rd_full), 0);
    chk("R10 wr_usedw", 32'(wr_usedw), 0);
    chk("R10 rd_usedw", 32'(rd_usedw), 0);
    chk("R10 rd_data", 32'(rd_data), 0);
    check_levels(0);

    // fill sweep: every level from 1 to depth
    for (int k = 0; k < 16; k++) begin
      push(8'(k * 37 + 5), acc);
      wr_idle();
      settle();
      check_levels(model.size());
    end

    // R2: write at full is dropped
    push(8'hEE, acc);
    wr_idle();
    settle();
    chk("R2 wr_usedw at full", 32'(wr_usedw), 16);
    check_levels(model.size());

    // drain sweep
    for (int j = 0; j < 8; j++) begin
      pop_check("drain");
      settle();
      check_levels(model.size());
    end

    // R3: read at empty is dropped, q holds
    q0 = rd_data;
    pop(acc, got);
    chk("R3 q hold at empty", 32'(got), 32'(q0));
    settle();
    chk("R3 rd_usedw at empty", 32'(rd_usedw), 0);
    chk("R3 wr_usedw at empty", 32'(wr_usedw), 0);

    // odd fill: a lone byte is not a readable word
    for (int k = 0; k < 3; k++) begin
      push(8'(8'hA0 + k), acc);
    end
    wr_idle();
    settle();
    check_levels(model.size());
    pop_check("odd");
    settle();
    check_levels(model.size());
    q0 = rd_data;
    pop(acc, got);
    chk("R3 q hold with one byte", 32'(got), 32'(q0));
    settle();
    check_levels(model.size());
    push(8'h5C, acc);
    wr_idle();
    settle();
    check_levels(model.size());
    pop_check("odd");
    settle();
    check_levels(model.size());

    // concurrent streaming with wrap-around and back-pressure
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          acc = 1'b0;
          while (!acc) push(8'(k * 13 + 7), acc);
          if (k % 7 == 6) wr_idle();
        end
        wr_idle();
      end
      begin
        int cnt = 0;
        logic        a;
        logic [15:0] g, e;
        while (cnt < 150) begin
          pop(a, g);
          if (a) begin
            e = {model[1], model[0]};
            chk("R1 R11 stream data", 32'(g), 32'(e));
            void'(model.pop_front());
            void'(model.pop_front());
            cnt++;
          end
          if (cnt % 5 == 0) repeat (2) @(posedge rd_clk);
        end
      end
    join
    settle();
    check_levels(model.size());

    summary();
    $finish;
  end
endmodule